// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits beside a program sequencer's fetch stage and repeats a single instruction, or a contiguous block of instructions, without spending any branch instructions on the loop. A loop-start command carries the address of the last instruction in the body and a pass count. When the command is seen, the controller records the address just after the issuing instruction as the top of the body. It then compares every fetch address against the recorded end address. While passes remain, a match steers the next fetch address back to the top of the body. On the final pass, or when the exit condition is raised at the end address, fetch falls through to the instruction after the body.

The next fetch address is produced combinationally from the current PC and the registered loop state, so the sequencer can feed it straight back into its PC register. A pass count of zero does not mean "skip": it selects the largest count the counter can hold, which is 256 passes with the default 8-bit count. A new start command always replaces whatever loop is in progress.

Top module: `zol_ctrl`

## Requirements
- R1: In a cycle with `start_i` high, `next_pc_o` is `pc_i + 1`, and `loop_active_o` is high in the following cycle. The top of the loop body is recorded as that `pc_i + 1`.
- R2: While a loop is active, a cycle where `pc_i` equals the recorded end address, at least one further pass remains and `exit_i` is low gives `next_pc_o` equal to the recorded top of the body.
- R3: In every other cycle `next_pc_o` is `pc_i + 1` (modulo 2^PC_W), including cycles inside the body that are not at the end address.
- R4: A loaded count N in 1..255 makes the body execute exactly N times before fetch falls through to the end address plus one.
- R5: A loaded count of zero makes the body execute 256 times; with the end address equal to the top of the body this repeats one instruction 256 times.
- R6: `loop_active_o` goes low in the cycle after the final end-address cycle, i.e. while the PC holds the address after the body, and stays low while no new start arrives.
- R7: `exit_i` high in an end-address cycle ends the loop on that pass (fall-through and R6 apply); `exit_i` high in any cycle whose PC is not the end address has no effect on `next_pc_o` or on the number of passes.
- R8: A start command while a loop is active discards the old loop; the new top, end address and count take effect at once, and the old end address no longer redirects.
- R9: After reset `loop_active_o` is low and `next_pc_o` is `pc_i + 1` for any `pc_i`, even one equal to `end_addr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Address of the instruction being fetched this cycle |
| start_i | input | 1 | Loop-start command issued by the instruction at `pc_i` |
| end_addr_i | input | PC_W | Address of the last instruction of the body, sampled with `start_i` |
| count_i | input | CNT_W | Pass count, sampled with `start_i`; zero selects 2^CNT_W |
| exit_i | input | 1 | Early termination condition, acted on only at the end address |
| next_pc_o | output | PC_W | Address to fetch in the next cycle |
| loop_active_o | output | 1 | High while a loop is in progress |

## Verification
`next_pc_o` is a same-cycle function of `pc_i` and the state registered at the previous edge, so the bench drives each fetch address just after a falling edge and compares `next_pc_o` one nanosecond later, before the next rising edge. `loop_active_o` passes through one register, so its effect is checked one cycle after the start command and one cycle after the final end-address cycle, at the address past the body. The bench feeds back the expected address each cycle and works out the whole fetch trace from the body length and the pass count, sweeping several body lengths against several counts, the zero count, early exit, exit noise away from the end, and a restart in mid-loop.

// File: rtl/zol_pkg.sv
package zol_pkg;

   // loop sequencing state
   typedef enum logic {
      ZOL_IDLE = 1'b0,
      ZOL_RUN  = 1'b1
   } zol_state_e;

   // passes selected by a count of zero when the wide option is on
   function automatic int unsigned zol_max_passes(input int unsigned cnt_w);
      return 32'd1 << cnt_w;
   endfunction

endpackage

// File: rtl/zol_loop_regs.sv
module zol_loop_regs #(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] end_i,
   output logic [PC_W-1:0] top_pc_o,
   output logic [PC_W-1:0] end_pc_o
);

   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   logic [PC_W-1:0] top_q;
   logic [PC_W-1:0] end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         end_q <= '0;
      end else if (load_i) begin
         top_q <= pc_i + PC_STEP;
         end_q <= end_i;
      end
   end

   assign top_pc_o = top_q;
   assign end_pc_o = end_q;

   // R1: recorded body top is the address following the start instruction
   assert_top_follows_start_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (top_pc_o == $past(pc_i) + PC_STEP));

   // R8: a reload replaces the end address
   assert_end_reload_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (end_pc_o == $past(end_i)));

   // both registers hold steady without a load
   assert_regs_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(top_pc_o) && $stable(end_pc_o)));

endmodule

// File: rtl/zol_pass_counter.sv
module zol_pass_counter #(
   parameter int CNT_W       = 8,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_cnt_i,
   input  logic             step_i,
   output logic             last_o
);

   localparam int             REM_W   = CNT_W + 1;
   localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);
   localparam logic [REM_W-1:0] REM_MAX = REM_ONE << CNT_W;

   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] load_val;
   logic             cnt_zero;

   assign cnt_zero = (load_cnt_i == '0);

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign load_val = cnt_zero ? REM_MAX : {1'b0, load_cnt_i};
      end else begin : g_zero_one
         assign load_val = cnt_zero ? REM_ONE : {1'b0, load_cnt_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= REM_ONE;
      end else if (load_i) begin
         rem_q <= load_val;
      end else if (step_i) begin
         rem_q <= rem_q - REM_ONE;
      end
   end

   assign last_o = (rem_q == REM_ONE);

   // R4: the remaining-pass count never underflows to zero
   assert_rem_nonzero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      rem_q != '0);

   // R4: the sequencer never steps the counter on its final pass
   assert_no_step_on_last_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |-> !last_o);

   generate
      if (ZERO_IS_MAX) begin : g_chk_max
         // R5: a zero count arms the full range of passes
         assert_zero_loads_max_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && cnt_zero) |=> (rem_q == REM_MAX));
      end
   endgenerate

endmodule

// File: rtl/zol_pc_select.sv
module zol_pc_select #(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc_i,
   input  logic            redirect_i,
   input  logic [PC_W-1:0] target_i,
   output logic [PC_W-1:0] next_pc_o
);

   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   logic [PC_W-1:0] seq_pc;

   assign seq_pc    = pc_i + PC_STEP;
   assign next_pc_o = redirect_i ? target_i : seq_pc;

   // R3: no redirect means sequential fetch
   assert_seq_fetch_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_i |-> (next_pc_o == pc_i + PC_STEP));

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
   parameter int PC_W        = 16,
   parameter int CNT_W       = 8,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  pc_i,
   input  logic             start_i,
   input  logic [PC_W-1:0]  end_addr_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             exit_i,
   output logic [PC_W-1:0]  next_pc_o,
   output logic             loop_active_o
);

   import zol_pkg::*;

   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   generate
      if (PC_W < 2 || PC_W > 64) begin : g_bad_pc_w
         $error("zol_ctrl: PC_W must lie in 2..64");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("zol_ctrl: CNT_W must lie in 1..16");
      end
      if (zol_max_passes(CNT_W) < 2) begin : g_bad_range
         $error("zol_ctrl: pass range too small");
      end
   endgenerate

   zol_state_e      state_q;
   zol_state_e      state_d;
   logic [PC_W-1:0] top_pc;
   logic [PC_W-1:0] end_pc;
   logic            last_pass;
   logic            at_end;
   logic            loop_back;
   logic            fall_out;

   assign at_end    = (state_q == ZOL_RUN) && (pc_i == end_pc) && !start_i;
   assign loop_back = at_end && !last_pass && !exit_i;
   assign fall_out  = at_end && (last_pass || exit_i);

   always_comb begin
      state_d = state_q;
      if (start_i) begin
         state_d = ZOL_RUN;
      end else if (fall_out) begin
         state_d = ZOL_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ZOL_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign loop_active_o = (state_q == ZOL_RUN);

   zol_loop_regs #(
      .PC_W (PC_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .pc_i     (pc_i),
      .end_i    (end_addr_i),
      .top_pc_o (top_pc),
      .end_pc_o (end_pc)
   );

   zol_pass_counter #(
      .CNT_W       (CNT_W),
      .ZERO_IS_MAX (ZERO_IS_MAX)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_i),
      .load_cnt_i (count_i),
      .step_i     (loop_back),
      .last_o     (last_pass)
   );

   zol_pc_select #(
      .PC_W (PC_W)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .pc_i       (pc_i),
      .redirect_i (loop_back),
      .target_i   (top_pc),
      .next_pc_o  (next_pc_o)
   );

   // R1: a start command activates the loop at the next edge
   assert_start_activates_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> loop_active_o);

   // R1: the start cycle itself fetches sequentially
   assert_start_seq_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (next_pc_o == pc_i + PC_STEP));

   // R6: the flag drops right after the final end-address cycle
   assert_fall_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      fall_out |=> !loop_active_o);

   // R6: the flag only rises through a start command
   assert_rise_needs_start_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_active_o) |-> $past(start_i));

   // R9: nothing redirects while idle
   assert_idle_seq_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !loop_active_o |-> (next_pc_o == pc_i + PC_STEP));

   // R7: exit away from the end address keeps the loop running
   assert_exit_off_end_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active_o && exit_i && !start_i && (pc_i != end_pc)) |=> loop_active_o);

endmodule

// File: tb/zol_ctrl_tb.sv
`timescale 1ns/1ps
module zol_ctrl_tb;

   localparam int PC_W  = 16;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [PC_W-1:0]  pc = '0;
   logic             start = 1'b0;
   logic [PC_W-1:0]  end_a = '0;
   logic [CNT_W-1:0] cnt = '0;
   logic             ex = 1'b0;
   logic [PC_W-1:0]  next_pc;
   logic             active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   zol_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .ZERO_IS_MAX(1'b1)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pc_i          (pc),
      .start_i       (start),
      .end_addr_i    (end_a),
      .count_i       (cnt),
      .exit_i        (ex),
      .next_pc_o     (next_pc),
      .loop_active_o (active)
   );

   task automatic chk_pc(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s next_pc actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s active actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input int p, input logic s, input int e, input int c, input logic x);
      @(negedge clk);
      pc    = PC_W'(p);
      start = s;
      end_a = PC_W'(e);
      cnt   = CNT_W'(c);
      ex    = x;
      #1;
   endtask

   // body of a loop whose start instruction sat at p0; passes = n
   task automatic run_body(input int p0, input int len, input int n, input int exit_pass,
                           input bit noisy, input int stop_after, input string tag);
      int total = ((exit_pass != 0) ? exit_pass : n) * len;
      int lim   = (stop_after != 0) ? stop_after : total;
      for (int k = 1; k <= lim; k++) begin
         int  p      = p0 + 1 + ((k - 1) % len);
         bit  is_end = (p == p0 + len);
         int  expn   = (k < total) ? (p0 + 1 + (k % len)) : (p0 + 1 + len);
         logic x     = ((exit_pass != 0) && (k == total)) ? 1'b1 : (noisy && !is_end);
         drive(p, 1'b0, 16'hFFFF, 0, x);
         chk_pc({tag, " R2 R3 body"}, next_pc, PC_W'(expn));
         chk_bit({tag, " R1 in loop"}, active, 1'b1);
      end
      if (lim == total) begin
         drive(p0 + 1 + len, 1'b0, p0 + 1 + len, 0, 1'b0);
         chk_bit({tag, " R6 flag dropped"}, active, 1'b0);
         chk_pc({tag, " R3 R6 after body"}, next_pc, PC_W'(p0 + 2 + len));
      end
   endtask

   task automatic run_loop(input int p0, input int len, input int c, input int exit_pass,
                           input bit noisy, input string tag);
      int n = (c == 0) ? 256 : c;
      drive(p0, 1'b1, p0 + len, c, 1'b0);
      chk_pc({tag, " R1 start cycle"}, next_pc, PC_W'(p0 + 1));
      run_body(p0, len, n, exit_pass, noisy, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lens[4]   = '{1, 2, 3, 5};
      int counts[4] = '{1, 2, 3, 7};
      int base;

      repeat (3) @(posedge clk);
      // R9: reset state
      drive(16'h0040, 1'b0, 16'h0040, 5, 1'b1);
      chk_bit("R9 reset", active, 1'b0);
      chk_pc("R9 reset", next_pc, 16'h0041);
      rst_n = 1'b1;
      drive(16'h0050, 1'b0, 16'h0050, 3, 1'b0);
      chk_bit("R9 idle", active, 1'b0);
      chk_pc("R9 R3 idle at end addr", next_pc, 16'h0051);
      drive(16'hFFFF, 1'b0, 16'hFFFF, 0, 1'b1);
      chk_pc("R3 wrap", next_pc, 16'h0000);

      // R2 R4: sweep body lengths against counts
      base = 16'h0200;
      foreach (lens[i]) begin
         foreach (counts[j]) begin
            run_loop(base, lens[i], counts[j], 0, 1'b0, "R4 sweep");
            base += 16'h40;
         end
      end

      // R4: largest explicit count
      run_loop(16'h0800, 1, 255, 0, 1'b0, "R4 count 255");
      // R5: zero count, single instruction and block
      run_loop(16'h0900, 1, 0, 0, 1'b0, "R5 single 256");
      run_loop(16'h0A00, 3, 0, 0, 1'b0, "R5 block 256");

      // R7: exit at end address of pass 4, noise elsewhere
      run_loop(16'h0B00, 3, 10, 4, 1'b1, "R7 early exit");
      run_loop(16'h0C00, 2, 3, 0, 1'b1, "R7 noise only");
      run_loop(16'h0C40, 4, 0, 1, 1'b0, "R7 exit first pass");

      // R8: restart in mid-loop
      drive(16'h0D00, 1'b1, 16'h0D03, 5, 1'b0);
      chk_pc("R8 first start", next_pc, 16'h0D01);
      run_body(16'h0D00, 3, 5, 0, 1'b0, 4, "R8 old loop");
      run_loop(16'h0D02, 2, 2, 0, 1'b0, "R8 new loop");
      // old end address 0x0D03 must not redirect after the new loop ended
      drive(16'h0D03, 1'b0, 16'h0D03, 0, 1'b0);
      chk_pc("R8 old end ignored", next_pc, 16'h0D04);
      chk_bit("R8 R6 stays idle", active, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule